// File: doc/BRIEF.md
# LCD Frame Sync Timing Generator

This block produces the horizontal and vertical synchronization strobes for a panel driver. It runs from a pixel-rate clock enable. A pixel counter divides each line into a programmable number of pixel periods. A line counter, advanced once per line, divides each frame into a programmable number of lines. The horizontal strobe marks the first pixel period of every line. The vertical strobe covers the first one, two or three lines of every frame, as a two-bit code selects.

Software configures the block through a byte-wide write-only port with five registers:

- a 16-bit line length held in two bytes;
- a 10-bit frame length held in two bytes;
- a control byte that holds the vertical width code and four phase bits.

The horizontal and vertical phase bits invert their strobes. The pixel-clock and load-strobe phase bits pass to the neighbouring panel logic.

All programmed values go into an active copy only at a frame boundary. A frame therefore never mixes old and new settings. Software must set the frame length to at least the visible plus dummy line count. The block does not check this.

Top module: `lcd_sync_gen`

## Requirements
- R1: A register is written on a rising clock edge when `wr_en` is high. The addresses are:
  - 0: line length bits 7:0
  - 1: line length bits 15:8
  - 2: frame length bits 7:0
  - 3: frame length bits 9:8
  - 4: control byte
- R2: At address 3, only `wr_data[1:0]` is stored, as frame length bits 9:8. Bits 7:2 of that byte are ignored.
- R3: A line lasts (L + 1) pixel enables, where L is the line length. The horizontal strobe is active only in the first pixel period of each line.
- R4: A frame lasts (F + 1) lines, where F is the frame length. The vertical strobe becomes active together with the horizontal strobe of line 0.
- R5: Control bits 1:0 give the vertical strobe width:
  - 00: 1 line
  - 01: 2 lines
  - 10: 3 lines
  - 11 (reserved): 1 line
- R6: The control byte holds four phase bits:
  - bit 6 = 1 makes `hsync` active-low;
  - bit 5 = 1 makes `vsync` active-low;
  - bit 7 is output on `pix_pol`;
  - bit 4 is output on `load_pol`.
  Bits 3:2 are unused.
- R7: Reset is synchronous and active-low. After reset:
  - the line and frame lengths are 0;
  - the control byte is 0xA0;
  - both counters are 0, so `hsync`=1, `vsync`=0, `pix_pol`=1 and `load_pol`=0.
- R8: New lengths, width and phases take effect only at the first pixel of the next frame. The frame in progress finishes with its old settings.
- R9: While `pix_en` is low, both counters hold and the outputs do not change.
- R10: Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_en | input | 1 | Pixel-rate clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address |
| wr_data | input | 8 | Register write data |
| hsync | output | 1 | Horizontal strobe, after phase |
| vsync | output | 1 | Vertical strobe, after phase |
| pix_pol | output | 1 | Active pixel-clock phase bit |
| load_pol | output | 1 | Active load-strobe phase bit |

## Verification
The bench sweeps every combination of three line lengths, three frame lengths and all four width codes. It rotates the four phase bits through all sixteen values, and compares both strobes at every pixel position against a position-arithmetic model:

- Line lengths of 0 and 1 separate a correct wrap compare from an off-by-one.
- Frame lengths shorter than the strobe width show whether the width is clipped to the frame.
- The reserved width code shows whether it falls back to one line.

Each new setting is written in the middle of a running frame, so a design that applies it early differs from the model within that frame. Two long configurations exercise:

- the upper line-length byte and frame-length bit 8;
- junk in the unused bits of address 3.

Irregular idle gaps between pixel enables show whether the counters hold.

// File: rtl/lcd_sync_pkg.sv
// Package lcd_sync_pkg
// Shared widths, register addresses, the configuration record and the
// reset configuration of the frame sync generator.
// Assumes byte-wide register data and a line length field wider than a byte.
package lcd_sync_pkg;

    localparam int DATA_W = 8;
    localparam int LH_W   = 16;
    localparam int LV_W   = 10;
    localparam int WC_W   = 2;

    localparam int REG_LINE_LO  = 0;
    localparam int REG_LINE_HI  = 1;
    localparam int REG_FRAME_LO = 2;
    localparam int REG_FRAME_HI = 3;
    localparam int REG_CTRL     = 4;

    // Control byte bit positions
    localparam int CB_PIX_POL  = 7;
    localparam int CB_HS_POL   = 6;
    localparam int CB_VS_POL   = 5;
    localparam int CB_LOAD_POL = 4;

    typedef struct packed {
        logic [LH_W-1:0] line_last;
        logic [LV_W-1:0] frame_last;
        logic [WC_W-1:0] vs_code;
        logic            pix_pol;
        logic            hs_pol;
        logic            vs_pol;
        logic            load_pol;
    } sync_cfg_t;

    localparam sync_cfg_t CFG_RESET = '{
        line_last:  '0,
        frame_last: '0,
        vs_code:    '0,
        pix_pol:    1'b1,
        hs_pol:     1'b0,
        vs_pol:     1'b1,
        load_pol:   1'b0
    };

    // Width code to line count; the reserved code falls back to one line
    function automatic logic [WC_W-1:0] vs_lines(input logic [WC_W-1:0] code);
        if (code == '1) return WC_W'(1);
        return code + WC_W'(1);
    endfunction

endpackage

// File: rtl/lcd_sync_regs.sv
// Module lcd_sync_regs
// Holds the written register file and the copy that is active for the current
// frame. The active copy loads only when load is high (the last pixel of a
// frame), so a frame never sees a partial update.
// Assumes ADDR_W is wide enough to hold address 4 and that writes are single cycle.
module lcd_sync_regs
    import lcd_sync_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    output sync_cfg_t         act_cfg
);

    localparam int LH_HI_W = LH_W - DATA_W;
    localparam int LV_HI_W = LV_W - DATA_W;

    sync_cfg_t live_q;
    sync_cfg_t act_q;
    logic      hit_unmapped;

    // Decode a write that lands outside the register map
    always_comb begin
        hit_unmapped = wr_en && (wr_addr > ADDR_W'(REG_CTRL));
    end

    // Capture software writes into the live register file
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= CFG_RESET;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(REG_LINE_LO)) begin
                live_q.line_last[DATA_W-1:0] <= wr_data;
            end else if (wr_addr == ADDR_W'(REG_LINE_HI)) begin
                live_q.line_last[LH_W-1:DATA_W] <= wr_data[LH_HI_W-1:0];
            end else if (wr_addr == ADDR_W'(REG_FRAME_LO)) begin
                live_q.frame_last[DATA_W-1:0] <= wr_data;
            end else if (wr_addr == ADDR_W'(REG_FRAME_HI)) begin
                live_q.frame_last[LV_W-1:DATA_W] <= wr_data[LV_HI_W-1:0];
            end else if (wr_addr == ADDR_W'(REG_CTRL)) begin
                live_q.pix_pol  <= wr_data[CB_PIX_POL];
                live_q.hs_pol   <= wr_data[CB_HS_POL];
                live_q.vs_pol   <= wr_data[CB_VS_POL];
                live_q.load_pol <= wr_data[CB_LOAD_POL];
                live_q.vs_code  <= wr_data[WC_W-1:0];
            end
        end
    end

    // Transfer the live settings to the active copy at a frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= CFG_RESET;
        end else if (load) begin
            act_q <= live_q;
        end
    end

    always_comb begin
        act_cfg = act_q;
    end

    // R10: a write outside the map leaves the register file untouched
    p_unmapped_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_unmapped |=> $stable(live_q));

    // R2: address 3 keeps only its two low data bits
    p_frame_hi_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(REG_FRAME_HI))
        |=> (live_q.frame_last[LV_W-1:DATA_W] == $past(wr_data[LV_HI_W-1:0])));

endmodule

// File: rtl/lcd_sync_pix_ctr.sv
// Module lcd_sync_pix_ctr
// Counts pixel enables within a line, from 0 to last_idx, then wraps.
// Flags the first pixel period of a line and the enable that closes the line.
// Assumes last_idx changes only while the count is 0 (frame boundary).
module lcd_sync_pix_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_en,
    input  logic [CNT_W-1:0] last_idx,
    output logic             line_start,
    output logic             line_end
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_last;

    // Compare the count with the programmed last pixel index
    always_comb begin
        at_last    = (cnt_q == last_idx);
        line_start = (cnt_q == '0);
        line_end   = pix_en && at_last;
    end

    // Advance the pixel position once per pixel enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pix_en) begin
            cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
        end
    end

    // R3: the position never passes the programmed line length
    p_pix_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_idx);

    // R9: without a pixel enable the position holds
    p_pix_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(cnt_q));

endmodule

// File: rtl/lcd_sync_frame_ctr.sv
// Module lcd_sync_frame_ctr
// Counts lines within a frame, from 0 to last_idx, advancing once per line.
// Decodes the vertical strobe as the first vs_width lines of the frame.
// Assumes adv pulses for one cycle at the end of each line.
module lcd_sync_frame_ctr #(
    parameter int CNT_W = 10,
    parameter int WID_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [CNT_W-1:0] last_idx,
    input  logic [WID_W-1:0] vs_width,
    output logic             frame_end,
    output logic             vs_act
);

    logic [CNT_W-1:0] idx_q;

    // Decode the frame end and the vertical strobe window
    always_comb begin
        frame_end = adv && (idx_q == last_idx);
        vs_act    = (idx_q < CNT_W'(vs_width));
    end

    // Advance the line index at each line end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (adv) begin
            idx_q <= (idx_q == last_idx) ? '0 : idx_q + CNT_W'(1);
        end
    end

    // R4: the line index never passes the programmed frame length
    p_line_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= last_idx);

    // R4: line 0 always carries the vertical strobe
    p_vs_first_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q == '0) |-> vs_act);

    // R5: no width code reaches a fourth line
    p_vs_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_q >= CNT_W'(3)) |-> !vs_act);

endmodule

// File: rtl/lcd_sync_gen.sv
// Module lcd_sync_gen
// Top level of the frame sync generator. It joins the register file, the
// pixel counter and the line counter, and applies the phase bits of the
// active configuration to the strobes.
// Assumes pix_en is a single-cycle enable at pixel rate. The outputs are
// decoded from flops and should be registered by the pad logic.
module lcd_sync_gen
    import lcd_sync_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hsync,
    output logic              vsync,
    output logic              pix_pol,
    output logic              load_pol
);

    sync_cfg_t       cfg;
    logic            line_start;
    logic            line_end;
    logic            frame_end;
    logic            vs_act;
    logic [WC_W-1:0] vs_width;

    lcd_sync_regs #(
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (frame_end),
        .act_cfg (cfg)
    );

    lcd_sync_pix_ctr #(
        .CNT_W (LH_W)
    ) i_pix_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_en     (pix_en),
        .last_idx   (cfg.line_last),
        .line_start (line_start),
        .line_end   (line_end)
    );

    // Translate the width code into a line count
    always_comb begin
        vs_width = vs_lines(cfg.vs_code);
    end

    lcd_sync_frame_ctr #(
        .CNT_W (LV_W),
        .WID_W (WC_W)
    ) i_frame_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (line_end),
        .last_idx  (cfg.frame_last),
        .vs_width  (vs_width),
        .frame_end (frame_end),
        .vs_act    (vs_act)
    );

    // Apply the active phase bits to the strobes
    always_comb begin
        hsync    = line_start ^ cfg.hs_pol;
        vsync    = vs_act ^ cfg.vs_pol;
        pix_pol  = cfg.pix_pol;
        load_pol = cfg.load_pol;
    end

    // R8: the active configuration changes only after a frame end
    p_cfg_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != $past(cfg)) |-> $past(frame_end));

    // R4: the vertical strobe starts together with a horizontal strobe
    p_vs_with_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_act) |-> line_start);

    // R3: the horizontal strobe lasts one pixel period when a line is longer than one
    p_hs_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && pix_en && cfg.line_last != '0) |=> !line_start);

endmodule

// File: tb/test_lcd_sync_gen.sv
// Bench for lcd_sync_gen: sweeps small configurations and compares the strobes
// at every pixel position against an arithmetic position model.
module test_lcd_sync_gen;
    import lcd_sync_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       hsync, vsync, pix_pol, load_pol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model: live (written) and current (active) settings
    logic [15:0] m_lh, c_lh;
    logic [9:0]  m_lv, c_lv;
    logic [1:0]  m_w,  c_w;
    logic        m_pp, m_ph, m_pv, m_pl;
    logic        c_pp, c_ph, c_pv, c_pl;
    int          pos;
    int          wraps;

    always #5 clk = ~clk;

    lcd_sync_gen i_lcd_sync_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_en   (pix_en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .hsync    (hsync),
        .vsync    (vsync),
        .pix_pol  (pix_pol),
        .load_pol (load_pol)
    );

    function automatic int width_of(input logic [1:0] code);
        return (code == 2'b11) ? 1 : int'(code) + 1; // R5 mapping, reserved -> 1
    endfunction

    task automatic check1(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s pos=%0d actual=%b expected=%b", req, what, pos, act, exp);
        end
    endtask

    task automatic check_outputs();
        int len = int'(c_lh) + 1;
        int line = pos / len;
        check1("R3", "hsync", hsync, ((pos % len) == 0) ^ c_ph);
        check1("R4,R5", "vsync", vsync, (line < width_of(c_w)) ^ c_pv);
        check1("R6", "pix_pol", pix_pol, c_pp);
        check1("R6", "load_pol", load_pol, c_pl);
    endtask

    // One pixel enable, optional idle cycles (R9), then the model advances.
    // Settings written mid-frame only reach the model at the wrap (R8).
    task automatic step(input int idle);
        @(negedge clk) pix_en = 1'b1;
        @(negedge clk) pix_en = 1'b0;
        repeat (idle) @(negedge clk);
        pos++;
        if (pos == (int'(c_lh) + 1) * (int'(c_lv) + 1)) begin
            pos = 0;
            wraps++;
            c_lh = m_lh; c_lv = m_lv; c_w = m_w;
            c_pp = m_pp; c_ph = m_ph; c_pv = m_pv; c_pl = m_pl;
        end
        check_outputs();
    endtask

    // Register write; the model follows R1, R2 and R10
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            3'd0: m_lh[7:0]  = d;
            3'd1: m_lh[15:8] = d;
            3'd2: m_lv[7:0]  = d;
            3'd3: m_lv[9:8]  = d[1:0];
            3'd4: begin
                m_pp = d[7]; m_ph = d[6]; m_pv = d[5]; m_pl = d[4]; m_w = d[1:0];
            end
            default: ;
        endcase
        check_outputs(); // a write never moves the strobes mid-frame (R8)
    endtask

    task automatic run_cfg(input logic [15:0] lh, input logic [9:0] lv,
                           input logic [7:0] ctrl, input logic [5:0] junk);
        wr(3'd5, 8'hFF); // R10: unmapped addresses
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        wr(3'd0, lh[7:0]);
        wr(3'd1, lh[15:8]);
        wr(3'd2, lv[7:0]);
        wr(3'd3, {junk, lv[9:8]}); // R2: junk in bits 7:2
        wr(3'd4, ctrl);
        wraps = 0;
        while (wraps < 3) step((pos % 3 == 1) ? 2 : 0);
    endtask

    initial begin
        m_lh = '0; m_lv = '0; m_w = '0;
        m_pp = 1'b1; m_ph = 1'b0; m_pv = 1'b1; m_pl = 1'b0;
        c_lh = m_lh; c_lv = m_lv; c_w = m_w;
        c_pp = m_pp; c_ph = m_ph; c_pv = m_pv; c_pl = m_pl;
        pos = 0; wraps = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        check1("R7", "hsync", hsync, 1'b1);
        check1("R7", "vsync", vsync, 1'b0);
        check1("R7", "pix_pol", pix_pol, 1'b1);
        check1("R7", "load_pol", load_pol, 1'b0);
        // R1: sweep of line length, frame length, width codes and phase bits
        begin
            int lh_set[3] = '{0, 1, 3};
            int lv_set[3] = '{0, 2, 4};
            int k = 0;
            for (int i = 0; i < 3; i++) begin
                for (int j = 0; j < 3; j++) begin
                    for (int w = 0; w < 4; w++) begin
                        logic [3:0] pol = 4'(k);
                        run_cfg(16'(lh_set[i]), 10'(lv_set[j]),
                                {pol, 2'b00, 2'(w)}, 6'(k * 5));
                        k++;
                    end
                end
            end
        end
        // Upper line-length byte, 3-line strobe
        run_cfg(16'h0102, 10'd1, 8'b0110_0010, 6'h00);
        // Frame-length bit 8 with junk at address 3, reserved width code (R5)
        run_cfg(16'h0000, 10'h105, 8'b1001_0011, 6'h3F);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R3 watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule